// File: doc/BRIEF.md
# PHY Management Command Unit

This unit sits on the host side of a PHY management link. Software writes a command word into a small register port. The word names a PHY address, a register number and an opcode, and it carries a start flag. When the start flag is set and the opcode is a read or a write, the unit performs one management access. A write sends the low 16 bits of the write-data register to the addressed PHY register. A read loads the addressed PHY register into the read-data register. Bit-level serial signalling is not modelled: the access completes one cycle after the command is taken.

The unit contains a model of one PHY, reachable at a parameterised address. The model holds a 32-entry by 16-bit register file. Most entries are plain storage. A few entries are computed when they are read: some from the link input and some from the advertisement register (index 4). An access to any other PHY address reaches no device. A read from such an address returns all ones, and a write to it is discarded.

Top module: `mdio_mgmt_unit`

## Requirements
- R1: A host read at register-port address 0 (command) returns the last command word written there, with bit 7 forced to 1. Address 1 returns the write-data register. Address 2 returns the read-data register, zero-extended.
- R2: A command with bit 11 set and opcode bits [15:14] = 1 targets PHY address bits [28:24] and register bits [20:16]. When the address is the local one (default 7), it stores the low 16 bits of the write-data register into that register. A later read of a plain-storage register returns that value.
- R3: A command with bit 11 set and opcode 2 loads the read-data register with the addressed register's read value.
- R4: A command with opcode 0 or 3, or any command with bit 11 clear, changes no PHY register and leaves the read-data register unchanged. It raises no done pulse.
- R5: A read from a PHY address other than the local one returns 0xFFFF. A write to such an address leaves every local register unchanged.
- R6: After reset, the local registers 0, 2, 3 and 4 read 0x3100, 0x0300, 0xE400 and 0x01E1. All other stored registers read 0, the read-data register reads 0, and the command register reads 0x80.
- R7: Register 1 reads 0x782E while the link input is high and 0 while it is low.
- R8: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R9: Register 17 reads 0x8000 whatever has been written to it.
- R10: While the link is high, register 18 reads bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with all other bits 0. While the link is low it reads 0.
- R11: Every local register write clears bit 15 of register 0, so register 0 written with 0xFFFF reads 0x7FFF.
- R12: For each accepted read or write command, the `done` output is high for exactly the second clock cycle after the cycle in which the command was written. At that point the read-data register already holds the read result. Back-to-back commands give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register-port write strobe |
| host_addr | input | 2 | Register-port address: 0 command, 1 write data, 2 read data |
| host_wdata | input | 32 | Register-port write data |
| host_rdata | output | 32 | Register-port read data, combinational from host_addr |
| phy_link | input | 1 | Link state seen by the PHY model |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
The case hardest to reach from the ports is a command arriving in the cycle while the previous access is still pending. Here the two pipeline stages hold different requests, and the read-data register must end with the second result. The bench writes two read commands on consecutive clock cycles. Its behavioural model, checked on every cycle, must see two adjacent done pulses and the second register's value. A second hard case is the derived registers changing underneath stored state. To cover it, the stimulus rewrites register 4 and toggles the link between reads of registers 1, 5 and 18.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   // command word field positions
   localparam int FLD_PHY_LSB = 24;
   localparam int FLD_REG_LSB = 16;
   localparam int FLD_OP_LSB  = 14;
   localparam int FLD_GO_BIT  = 11;
   localparam int RDY_BIT     = 7;
   localparam int FLD_ADDR_W  = 5;
   localparam int HOST_AW     = 2;

   typedef enum logic [1:0] {
      OP_RSV0  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_RSV3  = 2'd3
   } mgmt_op_e;

   typedef struct packed {
      logic [FLD_ADDR_W-1:0] phy;
      logic [FLD_ADDR_W-1:0] regn;
      mgmt_op_e              op;
   } access_req_t;

   localparam logic [HOST_AW-1:0] HA_CMD   = 2'd0;
   localparam logic [HOST_AW-1:0] HA_WDATA = 2'd1;
   localparam logic [HOST_AW-1:0] HA_RDATA = 2'd2;

   // PHY register indices with special behaviour
   localparam logic [FLD_ADDR_W-1:0] IX_CTRL    = 5'd0;
   localparam logic [FLD_ADDR_W-1:0] IX_STATUS  = 5'd1;
   localparam logic [FLD_ADDR_W-1:0] IX_ID_HI   = 5'd2;
   localparam logic [FLD_ADDR_W-1:0] IX_ID_LO   = 5'd3;
   localparam logic [FLD_ADDR_W-1:0] IX_ADV     = 5'd4;
   localparam logic [FLD_ADDR_W-1:0] IX_PARTNER = 5'd5;
   localparam logic [FLD_ADDR_W-1:0] IX_SPEED   = 5'd17;
   localparam logic [FLD_ADDR_W-1:0] IX_DIAG    = 5'd18;

   function automatic logic [15:0] phy_reset_word(input int idx);
      case (idx)
         0:       return 16'h3100;
         2:       return 16'h0300;
         3:       return 16'hE400;
         4:       return 16'h01E1;
         default: return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/phy_reg_model.sv
module phy_reg_model
   import mdio_mgmt_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  link_up,
   input  logic                  we,
   input  logic [FLD_ADDR_W-1:0] idx,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata
);

   localparam logic [DATA_W-1:0] SELF_CLR_MASK = DATA_W'(1) << (DATA_W - 1);
   localparam logic [DATA_W-1:0] STATUS_UP     = 16'h782E;
   localparam logic [DATA_W-1:0] PARTNER_BASE  = 16'h4001;
   localparam logic [DATA_W-1:0] ADV_ECHO_MASK = 16'h01E0;
   localparam logic [DATA_W-1:0] SPEED_WORD    = 16'h8000;

   if (DATA_W != 16) begin : g_bad_width
      initial $fatal(1, "phy_reg_model: DATA_W must be 16");
   end
   if (NUM_REGS <= int'(IX_DIAG) || NUM_REGS > (1 << FLD_ADDR_W)) begin : g_bad_depth
      initial $fatal(1, "phy_reg_model: NUM_REGS out of range");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] mem;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
      localparam logic [FLD_ADDR_W-1:0] CELL_IX  = FLD_ADDR_W'(gi);
      localparam logic [DATA_W-1:0]     CELL_RST = DATA_W'(phy_reset_word(gi));
      logic [DATA_W-1:0] cell_q;
      logic              hit;

      assign hit = we && (idx == CELL_IX);

      if (gi == int'(IX_CTRL)) begin : g_ctrl
         // any write to the file drops the self-clearing top bit here
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= CELL_RST;
            end else if (we) begin
               cell_q <= (hit ? wdata : cell_q) & ~SELF_CLR_MASK;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= CELL_RST;
            end else if (hit) begin
               cell_q <= wdata;
            end
         end
      end

      assign mem[gi] = cell_q;
   end

   logic [DATA_W-1:0] stored;
   logic [DATA_W-1:0] adv;

   always_comb begin
      stored = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == FLD_ADDR_W'(i)) stored = mem[i];
      end
   end

   assign adv = mem[IX_ADV];

   always_comb begin
      case (idx)
         IX_STATUS:  rdata = link_up ? STATUS_UP : '0;
         IX_PARTNER: rdata = PARTNER_BASE | (adv & ADV_ECHO_MASK);
         IX_SPEED:   rdata = SPEED_WORD;
         IX_DIAG: begin
            rdata = '0;
            if (link_up) begin
               rdata[10] = adv[7] | adv[8];
               rdata[11] = adv[8] | adv[6];
            end
         end
         default:    rdata = stored;
      endcase
   end

endmodule

// File: rtl/mdio_access_seq.sv
module mdio_access_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 7,
   parameter int DATA_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  access_req_t           req,
   input  logic [DATA_W-1:0]     wr_value,
   input  logic [DATA_W-1:0]     rf_rdata,
   output logic                  rf_we,
   output logic [FLD_ADDR_W-1:0] rf_idx,
   output logic [DATA_W-1:0]     rf_wdata,
   output logic                  rd_load,
   output logic [DATA_W-1:0]     rd_value,
   output logic                  done
);

   localparam logic [FLD_ADDR_W-1:0] LOCAL_ID = FLD_ADDR_W'(PHY_ADDR);
   localparam logic [DATA_W-1:0]     ABSENT   = '1;

   if (PHY_ADDR < 0 || PHY_ADDR >= (1 << FLD_ADDR_W)) begin : g_bad_addr
      initial $fatal(1, "mdio_access_seq: PHY_ADDR out of range");
   end

   logic        pend_v;
   access_req_t pend_q;
   logic        is_local;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_q <= '0;
         done   <= 1'b0;
      end else begin
         pend_v <= req_valid;
         done   <= pend_v;
         if (req_valid) pend_q <= req;
      end
   end

   assign is_local = (pend_q.phy == LOCAL_ID);
   assign rf_idx   = pend_q.regn;
   assign rf_wdata = wr_value;
   assign rf_we    = pend_v && (pend_q.op == OP_WRITE) && is_local;
   assign rd_load  = pend_v && (pend_q.op == OP_READ);
   assign rd_value = is_local ? rf_rdata : ABSENT;

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int HOST_W = 32,
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [HOST_W-1:0]  host_wdata,
   output logic [HOST_W-1:0]  host_rdata,
   input  logic               rd_load,
   input  logic [DATA_W-1:0]  rd_value,
   output logic [DATA_W-1:0]  wr_value,
   output logic               req_valid,
   output access_req_t        req,
   output logic [HOST_W-1:0]  rdata_q
);

   localparam logic [HOST_W-1:0] READY_MASK = HOST_W'(1) << RDY_BIT;

   if (HOST_W < FLD_PHY_LSB + FLD_ADDR_W || HOST_W < DATA_W) begin : g_bad_host
      initial $fatal(1, "mdio_host_regs: HOST_W too narrow");
   end

   logic [HOST_W-1:0] cmd_q;
   logic [HOST_W-1:0] wdata_q;
   logic              cmd_wr;
   mgmt_op_e          op_f;

   assign cmd_wr   = host_we && (host_addr == HA_CMD);
   assign op_f     = mgmt_op_e'(host_wdata[FLD_OP_LSB +: 2]);
   assign req.phy  = host_wdata[FLD_PHY_LSB +: FLD_ADDR_W];
   assign req.regn = host_wdata[FLD_REG_LSB +: FLD_ADDR_W];
   assign req.op   = op_f;
   assign req_valid = cmd_wr && host_wdata[FLD_GO_BIT] &&
                      ((op_f == OP_WRITE) || (op_f == OP_READ));
   assign wr_value = wdata_q[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (cmd_wr) cmd_q <= host_wdata;
         if (host_we && host_addr == HA_WDATA) wdata_q <= host_wdata;
         if (rd_load) rdata_q <= HOST_W'(rd_value);
      end
   end

   always_comb begin
      case (host_addr)
         HA_CMD:   host_rdata = cmd_q | READY_MASK;
         HA_WDATA: host_rdata = wdata_q;
         HA_RDATA: host_rdata = rdata_q;
         default:  host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mdio_mgmt_unit.sv
module mdio_mgmt_unit
   import mdio_mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 7,
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 16,
   parameter int HOST_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              phy_link,
   output logic              done
);

   logic                  req_valid;
   access_req_t           req;
   logic [DATA_W-1:0]     wr_value;
   logic [DATA_W-1:0]     rf_rdata;
   logic                  rf_we;
   logic [FLD_ADDR_W-1:0] rf_idx;
   logic [DATA_W-1:0]     rf_wdata;
   logic                  rd_load;
   logic [DATA_W-1:0]     rd_value;
   logic [HOST_W-1:0]     rdata_q;

   mdio_host_regs #(.HOST_W(HOST_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .rd_load    (rd_load),
      .rd_value   (rd_value),
      .wr_value   (wr_value),
      .req_valid  (req_valid),
      .req        (req),
      .rdata_q    (rdata_q)
   );

   mdio_access_seq #(.PHY_ADDR(PHY_ADDR), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req       (req),
      .wr_value  (wr_value),
      .rf_rdata  (rf_rdata),
      .rf_we     (rf_we),
      .rf_idx    (rf_idx),
      .rf_wdata  (rf_wdata),
      .rd_load   (rd_load),
      .rd_value  (rd_value),
      .done      (done)
   );

   phy_reg_model #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_phy (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (phy_link),
      .we      (rf_we),
      .idx     (rf_idx),
      .wdata   (rf_wdata),
      .rdata   (rf_rdata)
   );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
   import mdio_mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 7,
   parameter int HOST_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [1:0]        host_addr,
   input logic [HOST_W-1:0] host_wdata,
   input logic [HOST_W-1:0] host_rdata,
   input logic              done,
   input logic [HOST_W-1:0] rd_q
);

   logic [1:0]            op;
   logic [FLD_ADDR_W-1:0] phy;
   logic [FLD_ADDR_W-1:0] regn;
   logic                  go_any;
   logic                  go_ok;
   logic                  go_bad;

   assign op     = host_wdata[FLD_OP_LSB +: 2];
   assign phy    = host_wdata[FLD_PHY_LSB +: FLD_ADDR_W];
   assign regn   = host_wdata[FLD_REG_LSB +: FLD_ADDR_W];
   assign go_any = host_we && (host_addr == HA_CMD) && host_wdata[FLD_GO_BIT];
   assign go_ok  = go_any && (op == 2'd1 || op == 2'd2);
   assign go_bad = go_any && (op == 2'd0 || op == 2'd3);

   p_ready_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == HA_CMD) |-> host_rdata[RDY_BIT]);

   p_done_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      go_ok |-> ##2 done);

   p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(go_ok, 2));

   p_inert_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go_bad |-> ##2 !done);

   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_q));

   p_absent_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_ok && op == 2'd2 && phy != FLD_ADDR_W'(PHY_ADDR))
      |-> ##2 (rd_q == HOST_W'(16'hFFFF)));

   p_speed_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (go_ok && op == 2'd2 && phy == FLD_ADDR_W'(PHY_ADDR) && regn == IX_SPEED)
      |-> ##2 (rd_q == HOST_W'(16'h8000)));

endmodule

bind mdio_mgmt_unit mdio_mgmt_checker #(.PHY_ADDR(PHY_ADDR), .HOST_W(HOST_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .done       (done),
   .rd_q       (rdata_q)
);

// File: tb/sim_mdio_mgmt_unit.sv
module sim_mdio_mgmt_unit;

   localparam int LPHY = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = 2'd2;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        phy_link = 1'b1;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   mdio_mgmt_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .phy_link   (phy_link),
      .done       (done)
   );

   // ---------------- behavioural reference ----------------
   int          mregs [32];
   logic [31:0] m_cmd;
   logic [31:0] m_wd;
   logic [31:0] m_rd;
   bit          m_done;
   bit          m_pv;
   int          m_pop, m_pphy, m_preg;

   function automatic int mread(input int r);
      int a;
      a = mregs[4];
      case (r)
         1:  return phy_link ? 'h782E : 0;
         5:  return 'h4000 | (a & 'h1E0) | 1;
         17: return 'h8000;
         18: return phy_link ? (((((a >> 8) | (a >> 6)) & 1) << 11) |
                                ((((a >> 7) | (a >> 8)) & 1) << 10)) : 0;
         default: return mregs[r];
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (mregs[i]) mregs[i] = 0;
         mregs[0] = 'h3100; mregs[2] = 'h0300; mregs[3] = 'hE400; mregs[4] = 'h01E1;
         m_cmd = '0; m_wd = '0; m_rd = '0; m_done = 0; m_pv = 0;
      end else begin
         m_done = m_pv;
         if (m_pv) begin
            if (m_pop == 1 && m_pphy == LPHY) begin
               mregs[m_preg] = int'(m_wd & 32'hFFFF);
               mregs[0] = mregs[0] & ~'h8000;
            end
            if (m_pop == 2) m_rd = (m_pphy == LPHY) ? 32'(mread(m_preg)) : 32'hFFFF;
         end
         m_pv = 0;
         if (host_we && host_addr == 2'd0) begin
            m_cmd = host_wdata;
            if (host_wdata[11] && (host_wdata[15:14] == 2'd1 || host_wdata[15:14] == 2'd2)) begin
               m_pv   = 1;
               m_pop  = int'(host_wdata[15:14]);
               m_pphy = int'(host_wdata[28:24]);
               m_preg = int'(host_wdata[20:16]);
            end
         end
         if (host_we && host_addr == 2'd1) m_wd = host_wdata;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         check("R12 done", {31'b0, done}, {31'b0, m_done});
         if (host_addr == 2'd2) check("R3 read-data", host_rdata, m_rd);
         if (host_addr == 2'd0) check("R1 command", host_rdata, m_cmd | 32'h80);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] mk(input int phy, input int r, input int op, input bit go);
      return (32'(phy) << 24) | (32'(r) << 16) | (32'(op) << 14) | (32'(go) << 11);
   endfunction

   task automatic host_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0; host_addr = 2'd2;
   endtask

   task automatic host_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      host_addr = a;
      #2;
      check(tag, host_rdata, exp);
      host_addr = 2'd2;
   endtask

   task automatic phy_read(input int phy, input int r, input logic [31:0] exp, input string tag);
      host_write(2'd0, mk(phy, r, 2, 1'b1));
      @(negedge clk);
      #2;
      check(tag, host_rdata, exp);
   endtask

   task automatic phy_write(input int phy, input int r, input logic [31:0] d);
      host_write(2'd1, d);
      host_write(2'd0, mk(phy, r, 1, 1'b1));
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset state
      host_read(2'd0, 32'h80, "R6 command reset");
      host_read(2'd2, 32'h0, "R6 read-data reset");
      phy_read(LPHY, 0, 32'h3100, "R6 reg0");
      phy_read(LPHY, 2, 32'h0300, "R6 reg2");
      phy_read(LPHY, 3, 32'hE400, "R6 reg3");
      phy_read(LPHY, 4, 32'h01E1, "R6 reg4");
      phy_read(LPHY, 9, 32'h0, "R6 reg9");

      // derived registers
      phy_read(LPHY, 1, 32'h782E, "R7 status link up");
      phy_read(LPHY, 5, 32'h41E1, "R8 partner default");
      phy_read(LPHY, 17, 32'h8000, "R9 speed");
      phy_read(LPHY, 18, 32'h0C00, "R10 diag default");
      phy_write(LPHY, 4, 32'h0061);
      phy_read(LPHY, 5, 32'h4061, "R8 partner adv 0061");
      phy_read(LPHY, 18, 32'h0800, "R10 diag adv 0061");
      phy_write(LPHY, 4, 32'h0081);
      phy_read(LPHY, 4, 32'h0081, "R2 adv stored");
      phy_read(LPHY, 5, 32'h4081, "R8 partner adv 0081");
      phy_read(LPHY, 18, 32'h0400, "R10 diag adv 0081");
      phy_link = 1'b0;
      phy_read(LPHY, 1, 32'h0, "R7 status link down");
      phy_read(LPHY, 18, 32'h0, "R10 diag link down");
      phy_link = 1'b1;

      // R2 / R11 / R9 writes
      phy_write(LPHY, 9, 32'hABCD_BEEF);
      phy_read(LPHY, 9, 32'hBEEF, "R2 reg9 write");
      phy_write(LPHY, 0, 32'hFFFF);
      phy_read(LPHY, 0, 32'h7FFF, "R11 reg0 self-clear");
      phy_write(LPHY, 17, 32'h1234);
      phy_read(LPHY, 17, 32'h8000, "R9 speed after write");

      // R5 absent device
      phy_read(3, 9, 32'hFFFF, "R5 absent read");
      phy_write(3, 9, 32'h1234);
      phy_read(LPHY, 9, 32'hBEEF, "R5 absent write ignored");

      // R4 inert commands
      host_write(2'd0, mk(LPHY, 2, 0, 1'b1));
      host_write(2'd0, mk(LPHY, 3, 3, 1'b1));
      host_write(2'd0, mk(LPHY, 4, 2, 1'b0));
      repeat (3) @(negedge clk);
      host_read(2'd2, 32'hBEEF, "R4 read-data untouched");
      host_write(2'd1, 32'h5555);
      host_write(2'd0, mk(LPHY, 9, 3, 1'b1));
      host_write(2'd0, mk(LPHY, 9, 1, 1'b0));
      phy_read(LPHY, 9, 32'hBEEF, "R4 reg9 untouched");

      // R1 command readback
      host_write(2'd0, 32'h1F1F_0000);
      host_read(2'd0, 32'h1F1F_0080, "R1 command readback");
      host_read(2'd1, 32'h5555, "R1 write-data readback");

      // R12 back-to-back reads
      @(negedge clk);
      host_we = 1'b1; host_addr = 2'd0; host_wdata = mk(LPHY, 2, 2, 1'b1);
      @(negedge clk);
      host_wdata = mk(LPHY, 3, 2, 1'b1);
      @(negedge clk);
      host_we = 1'b0; host_addr = 2'd2;
      @(negedge clk);
      #2;
      check("R12 back-to-back done", {31'b0, done}, 32'h1);
      check("R12 back-to-back data", host_rdata, 32'hE400);
      repeat (3) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule